// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath

This block is the 32-bit execution datapath of a multi-cycle, microcoded processor. Every transfer between storage elements crosses one shared 32-bit bus. In each cycle a microcontroller supplies a horizontal control word, and the datapath reports three things back to it: the opcode held in the instruction register, a flag that is set when operand register A is zero, and the busy line of memory. The sequencer that produces the control word lies outside this block.

Four sources can drive the bus: the ALU, the register file, the memory read port and the immediate extender. At most one of them drives it in any cycle. Four registers can load the bus value at the clock edge: the instruction register, the two ALU operand registers A and B, and the memory-address register. The register file holds the 32 general registers and has one extra entry that holds the program counter. The register it accesses is selected from the rs, rt or rd field of the instruction, or from two fixed indices: one for the link register and one for the program-counter entry. Memory may be slow and may take a variable number of cycles. It is reached only through the memory-address register, and it keeps its busy line high until an access completes.

Top module: `ubus_datapath`

## Requirements
- R1: At most one of `drv_alu_i`, `drv_reg_i`, `drv_mem_i`, `drv_imm_i` is high in a cycle, and the high one places its source on the bus. When none of them is high, the bus value is zero.
- R2: When `ld_ir_i`, `ld_a_i`, `ld_b_i` or `ld_ma_i` is high at a rising clock edge, the matching register (IR, A, B, MA) takes the bus value. Each register keeps its value in all other cycles.
- R3: `reg_sel_i` picks the register-file entry as follows: 0 selects IR[25:21], 1 selects IR[20:16], 2 selects IR[15:11], 3 selects entry 31 (link) and 4 selects entry 32 (program counter). When `reg_wr_i` is high at a rising edge, the bus value is written into the selected entry. When `drv_reg_i` is high, the selected entry is placed on the bus.
- R4: Entry 0 always reads as zero, and a write to entry 0 has no effect.
- R5: The immediate is IR[15:0]. `ext_sel_i` gives the extension: 0 sign-extends it, 1 zero-extends it, 2 shifts it left by 2 and then sign-extends it (branch offset), and 3 behaves like 0.
- R6: `alu_op_i` selects the ALU result: 0 gives A, 1 gives A+4, 2 gives A+B, and 3 gives the jump target {A[31:28], B[25:0], 2'b00}. Codes 5 to 7 give A.
- R7: `alu_op_i` = 4 takes its function from the instruction. When IR[31:26] is 0, IR[5:0] selects: 0x20 add, 0x22 subtract (A-B), 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than. Otherwise IR[31:26] selects: 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, 0x0E xor. Any other code adds.
- R8: `mem_addr_o` is MA, and `mem_wdata_o` is the bus value. `mem_we_o` follows `mem_we_i`. `mem_req_o` is high when `drv_mem_i` or `mem_we_i` is high. `busy_o` follows `mem_busy_i`. When `drv_mem_i` is high, `mem_rdata_i` is placed on the bus.
- R9: `opcode_o` is IR[31:26]. `zero_o` is high exactly when A equals zero.
- R10: While `rst_ni` is low, IR, A, B, MA and every register-file entry, including the program counter, are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drv_alu_i | input | 1 | ALU result drives the bus |
| drv_reg_i | input | 1 | Selected register-file entry drives the bus |
| drv_mem_i | input | 1 | Memory read data drives the bus |
| drv_imm_i | input | 1 | Extended immediate drives the bus |
| ld_ir_i | input | 1 | Load IR from the bus |
| ld_a_i | input | 1 | Load A from the bus |
| ld_b_i | input | 1 | Load B from the bus |
| ld_ma_i | input | 1 | Load MA from the bus |
| reg_wr_i | input | 1 | Write the bus into the selected entry |
| reg_sel_i | input | 3 | Register-file entry select |
| ext_sel_i | input | 2 | Immediate extension mode |
| alu_op_i | input | 3 | ALU operation |
| mem_we_i | input | 1 | Memory write request |
| mem_rdata_i | input | 32 | Memory read data |
| mem_busy_i | input | 1 | Memory access in progress |
| mem_addr_o | output | 32 | Memory address (MA) |
| mem_wdata_o | output | 32 | Memory write data (the bus) |
| mem_we_o | output | 1 | Memory write enable |
| mem_req_o | output | 1 | Memory access enable |
| opcode_o | output | 6 | IR[31:26] to the controller |
| zero_o | output | 1 | A equals zero |
| busy_o | output | 1 | Memory busy to the controller |

## Verification
The only register that can be seen directly at the ports is MA, so any internal state is made visible by driving it onto the bus and loading it into MA. A wrong value in A, B, IR or a register-file entry then appears on `mem_addr_o` one clock edge after the transfer. Corruption in IR also appears at once on `opcode_o`, and corruption in A appears at once on `zero_o`. A mistake in register selection or in the entry-0 guard shows up as a wrong read-back on the next transfer cycle.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned N_GPR     = 32;
  localparam int unsigned N_ENT     = N_GPR + 1;
  localparam int unsigned RAW       = $clog2(N_ENT);
  localparam int unsigned PC_IDX    = N_GPR;
  localparam int unsigned LINK_IDX  = N_GPR - 1;

  localparam logic [2:0] SEL_RS   = 3'd0;
  localparam logic [2:0] SEL_RT   = 3'd1;
  localparam logic [2:0] SEL_RD   = 3'd2;
  localparam logic [2:0] SEL_LINK = 3'd3;
  localparam logic [2:0] SEL_PC   = 3'd4;

  localparam logic [1:0] EXT_SGN  = 2'd0;
  localparam logic [1:0] EXT_ZER  = 2'd1;
  localparam logic [1:0] EXT_BRO  = 2'd2;

  localparam logic [2:0] OP_PASS  = 3'd0;
  localparam logic [2:0] OP_INC4  = 3'd1;
  localparam logic [2:0] OP_ADD   = 3'd2;
  localparam logic [2:0] OP_JMP   = 3'd3;
  localparam logic [2:0] OP_FUNC  = 3'd4;
endpackage

// File: rtl/ubus_regfile.sv
module ubus_regfile
  import ubus_pkg::*;
#(
  parameter int unsigned WIDTH   = DW,
  parameter int unsigned ENTRIES = N_ENT,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] ent_q [ENTRIES];

  // entry 0 is hard zero; no storage
  assign ent_q[0] = '0;

  for (genvar g = 1; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ent_q[g] <= '0;
      else if (we_i && addr_i == AW'(g))    ent_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (addr_i == AW'(i)) rdata_o = ent_q[i];
  end
endmodule

// File: rtl/ubus_imm_ext.sv
module ubus_imm_ext
  import ubus_pkg::*;
(
  input  logic [15:0]   imm_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] ext_o
);
  always_comb begin
    unique case (sel_i)
      EXT_ZER: ext_o = {{(DW-16){1'b0}}, imm_i};
      EXT_BRO: ext_o = {{(DW-18){imm_i[15]}}, imm_i, 2'b00};
      default: ext_o = {{(DW-16){imm_i[15]}}, imm_i};
    endcase
  end
endmodule

// File: rtl/ubus_alu.sv
module ubus_alu
  import ubus_pkg::*;
(
  input  logic [2:0]    op_i,
  input  logic [5:0]    opc_i,
  input  logic [5:0]    fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  typedef enum logic [2:0] {F_ADD, F_SUB, F_AND, F_OR, F_XOR, F_SLT} fn_e;
  fn_e fn;

  // register form decodes func, immediate form decodes opcode
  always_comb begin
    fn = F_ADD;
    if (opc_i == 6'h00) begin
      unique case (fn_i)
        6'h22: fn = F_SUB;
        6'h24: fn = F_AND;
        6'h25: fn = F_OR;
        6'h26: fn = F_XOR;
        6'h2A: fn = F_SLT;
        default: fn = F_ADD;
      endcase
    end else begin
      unique case (opc_i)
        6'h0A: fn = F_SLT;
        6'h0C: fn = F_AND;
        6'h0D: fn = F_OR;
        6'h0E: fn = F_XOR;
        default: fn = F_ADD;
      endcase
    end
  end

  logic [DW-1:0] fres;
  always_comb begin
    unique case (fn)
      F_SUB:   fres = a_i - b_i;
      F_AND:   fres = a_i & b_i;
      F_OR:    fres = a_i | b_i;
      F_XOR:   fres = a_i ^ b_i;
      F_SLT:   fres = {{(DW-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: fres = a_i + b_i;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_INC4: y_o = a_i + DW'(4);
      OP_ADD:  y_o = a_i + b_i;
      OP_JMP:  y_o = {a_i[DW-1:DW-4], b_i[DW-7:0], 2'b00};
      OP_FUNC: y_o = fres;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
  import ubus_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drv_alu_i,
  input  logic          drv_reg_i,
  input  logic          drv_mem_i,
  input  logic          drv_imm_i,
  input  logic          ld_ir_i,
  input  logic          ld_a_i,
  input  logic          ld_b_i,
  input  logic          ld_ma_i,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [1:0]    ext_sel_i,
  input  logic [2:0]    alu_op_i,
  input  logic          mem_we_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_busy_i,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_req_o,
  output logic [5:0]    opcode_o,
  output logic          zero_o,
  output logic          busy_o
);
  logic [DW-1:0] ir_q, a_q, b_q, ma_q;
  logic [DW-1:0] bus_w, alu_w, reg_w, imm_w;
  logic [RAW-1:0] ra_w;

  always_comb begin
    unique case (reg_sel_i)
      SEL_RS:   ra_w = RAW'(ir_q[25:21]);
      SEL_RT:   ra_w = RAW'(ir_q[20:16]);
      SEL_RD:   ra_w = RAW'(ir_q[15:11]);
      SEL_LINK: ra_w = RAW'(LINK_IDX);
      default:  ra_w = RAW'(PC_IDX);
    endcase
  end

  ubus_regfile #(.WIDTH(DW), .ENTRIES(N_ENT)) u_rf (
    .clk_i, .rst_ni, .addr_i(ra_w), .we_i(reg_wr_i), .wdata_i(bus_w), .rdata_o(reg_w)
  );

  ubus_imm_ext u_ext (.imm_i(ir_q[15:0]), .sel_i(ext_sel_i), .ext_o(imm_w));

  ubus_alu u_alu (
    .op_i(alu_op_i), .opc_i(ir_q[31:26]), .fn_i(ir_q[5:0]),
    .a_i(a_q), .b_i(b_q), .y_o(alu_w)
  );

  // one-hot AND-OR mux stands in for tristate drivers
  assign bus_w = ({DW{drv_alu_i}} & alu_w) | ({DW{drv_reg_i}} & reg_w)
               | ({DW{drv_mem_i}} & mem_rdata_i) | ({DW{drv_imm_i}} & imm_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0; a_q <= '0; b_q <= '0; ma_q <= '0;
    end else begin
      if (ld_ir_i) ir_q <= bus_w;
      if (ld_a_i)  a_q  <= bus_w;
      if (ld_b_i)  b_q  <= bus_w;
      if (ld_ma_i) ma_q <= bus_w;
    end
  end

  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = bus_w;
  assign mem_we_o    = mem_we_i;
  assign mem_req_o   = drv_mem_i | mem_we_i;
  assign busy_o      = mem_busy_i;
  assign opcode_o    = ir_q[31:26];
  assign zero_o      = (a_q == '0);
endmodule

// File: rtl/ubus_datapath_chk.sv
module ubus_datapath_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  drv,
  input logic [31:0] bus,
  input logic        ld_a,
  input logic        ld_ma,
  input logic        ld_ir,
  input logic [31:0] ma,
  input logic [5:0]  opcode,
  input logic        zero,
  input logic        rs_read,
  input logic [4:0]  rs_fld
);
  a_r1_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(drv) <= 1);

  a_r1_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv == 4'b0) |-> (bus == 32'h0));

  a_r2_ma_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ma |=> (ma == $past(bus)));

  a_r2_ma_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ma |=> $stable(ma));

  a_r4_r0_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_read && rs_fld == 5'd0 && drv == 4'b0100) |-> (bus == 32'h0));

  a_r9_zero_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_a && bus == 32'h0) |=> zero);

  a_r9_opcode_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ir |=> (opcode == $past(bus[31:26])));
endmodule

bind ubus_datapath ubus_datapath_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .drv     ({drv_alu_i, drv_reg_i, drv_mem_i, drv_imm_i}),
  .bus     (bus_w),
  .ld_a    (ld_a_i),
  .ld_ma   (ld_ma_i),
  .ld_ir   (ld_ir_i),
  .ma      (mem_addr_o),
  .opcode  (opcode_o),
  .zero    (zero_o),
  .rs_read (reg_sel_i == 3'd0),
  .rs_fld  (ir_q[25:21])
);

// File: tb/ubus_datapath_test.sv
module ubus_datapath_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic drv_alu, drv_reg, drv_mem, drv_imm, ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_we, mem_busy;
  logic [2:0] reg_sel, alu_op;
  logic [1:0] ext_sel;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_we_o, mem_req, zero, busy;
  logic [5:0] opcode;

  ubus_datapath uut (
    .clk_i(clk), .rst_ni(rst_n),
    .drv_alu_i(drv_alu), .drv_reg_i(drv_reg), .drv_mem_i(drv_mem), .drv_imm_i(drv_imm),
    .ld_ir_i(ld_ir), .ld_a_i(ld_a), .ld_b_i(ld_b), .ld_ma_i(ld_ma),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .ext_sel_i(ext_sel), .alu_op_i(alu_op),
    .mem_we_i(mem_we), .mem_rdata_i(mem_rdata), .mem_busy_i(mem_busy),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we_o), .mem_req_o(mem_req),
    .opcode_o(opcode), .zero_o(zero), .busy_o(busy)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    {drv_alu, drv_reg, drv_mem, drv_imm, ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_we} = '0;
    reg_sel = 3'd0; alu_op = 3'd0; ext_sel = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  // which: 0 IR, 1 A, 2 B, 3 MA
  task automatic mload(input int which, input logic [31:0] v);
    drv_mem = 1'b1; mem_rdata = v;
    ld_ir = (which == 0); ld_a = (which == 1); ld_b = (which == 2); ld_ma = (which == 3);
    tick();
  endtask

  task automatic rwrite(input logic [2:0] sel, input logic [31:0] v);
    drv_mem = 1'b1; mem_rdata = v; reg_sel = sel; reg_wr = 1'b1;
    tick();
  endtask

  task automatic rpeek(input logic [2:0] sel, output logic [31:0] v);
    drv_reg = 1'b1; reg_sel = sel; ld_ma = 1'b1;
    tick(); v = mem_addr;
  endtask

  task automatic apeek(input logic [2:0] op, output logic [31:0] v);
    drv_alu = 1'b1; alu_op = op; ld_ma = 1'b1;
    tick(); v = mem_addr;
  endtask

  task automatic ipeek(input logic [1:0] sel, output logic [31:0] v);
    drv_imm = 1'b1; ext_sel = sel; ld_ma = 1'b1;
    tick(); v = mem_addr;
  endtask

  // {op, ir, a, b, expected}
  localparam int NV = 11;
  localparam logic [130:0] VEC [NV] = '{
    {3'd0, 32'h00000000, 32'h12345678, 32'h00000000, 32'h12345678},
    {3'd1, 32'h00000000, 32'hFFFFFFFE, 32'h00000000, 32'h00000002},
    {3'd2, 32'h00000000, 32'h00000005, 32'hFFFFFFFF, 32'h00000004},
    {3'd3, 32'h00000000, 32'hA0000000, 32'h03FFFFFF, 32'hAFFFFFFC},
    {3'd3, 32'h00000000, 32'hA0000000, 32'hFC000001, 32'hA0000004},
    {3'd4, 32'h00000022, 32'h0000000A, 32'h00000003, 32'h00000007},
    {3'd4, 32'h0000002A, 32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    {3'd4, 32'h00000024, 32'h0000F0F0, 32'h0000FF00, 32'h0000F000},
    {3'd4, 32'h00000026, 32'h000000FF, 32'h0000000F, 32'h000000F0},
    {3'd4, 32'h34000000, 32'h00000100, 32'h00000001, 32'h00000101},
    {3'd4, 32'h28000000, 32'h00000005, 32'h00000003, 32'h00000000}
  };

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(); mem_rdata = '0; mem_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 ma after reset", mem_addr, 32'h0);
    chk("R10 opcode after reset", {26'h0, opcode}, 32'h0);
    chk("R10 zero flag after reset", {31'h0, zero}, 32'h1);
    rpeek(3'd4, v); chk("R10 pc after reset", v, 32'h0);

    // R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      mload(0, VEC[i][127:96]);
      mload(1, VEC[i][95:64]);
      mload(2, VEC[i][63:32]);
      apeek(VEC[i][130:128], v);
      chk($sformatf("R6/R7 alu vec %0d", i), v, VEC[i][31:0]);
    end

    // R1 idle bus reads zero
    mload(3, 32'h5555AAAA);
    ld_ma = 1'b1; tick();
    chk("R1 idle bus zero", mem_addr, 32'h0);

    // R2 hold without load
    mload(3, 32'h00000123);
    tick();
    chk("R2 ma holds", mem_addr, 32'h00000123);

    // R3 selection: rs=1 rt=2 rd=3
    mload(0, 32'h00221800);
    rwrite(3'd0, 32'hAAAA0001);
    rwrite(3'd1, 32'hBBBB0002);
    rwrite(3'd2, 32'hCCCC0003);
    rwrite(3'd3, 32'hDDDD001F);
    rwrite(3'd4, 32'h00000040);
    rpeek(3'd0, v); chk("R3 rs read", v, 32'hAAAA0001);
    rpeek(3'd1, v); chk("R3 rt read", v, 32'hBBBB0002);
    rpeek(3'd2, v); chk("R3 rd read", v, 32'hCCCC0003);
    rpeek(3'd3, v); chk("R3 link read", v, 32'hDDDD001F);
    rpeek(3'd4, v); chk("R3 pc read", v, 32'h00000040);
    // rs=31 reaches the same entry as link; rd=1 reaches rs entry
    mload(0, 32'h03E00800);
    rpeek(3'd0, v); chk("R3 rs=31 is link", v, 32'hDDDD001F);
    rpeek(3'd2, v); chk("R3 rd=1 entry", v, 32'hAAAA0001);

    // R4 r0 write ignored
    mload(0, 32'h00000000);
    rwrite(3'd0, 32'hDEADBEEF);
    rpeek(3'd0, v); chk("R4 r0 reads zero", v, 32'h0);
    rpeek(3'd4, v); chk("R4 pc untouched", v, 32'h00000040);

    // R5 extension
    mload(0, 32'h00008001);
    ipeek(2'd0, v); chk("R5 sign ext", v, 32'hFFFF8001);
    ipeek(2'd1, v); chk("R5 zero ext", v, 32'h00008001);
    ipeek(2'd2, v); chk("R5 branch offset", v, 32'hFFFE0004);
    ipeek(2'd3, v); chk("R5 code 3 as sign", v, 32'hFFFF8001);
    mload(0, 32'h00007FFF);
    ipeek(2'd2, v); chk("R5 positive offset", v, 32'h0001FFFC);

    // R8 memory interface
    mem_we = 1'b1; drv_reg = 1'b1; reg_sel = 3'd4; mem_busy = 1'b1;
    #1;
    chk("R8 wdata is bus", mem_wdata, 32'h00000040);
    chk("R8 we", {31'h0, mem_we_o}, 32'h1);
    chk("R8 req on write", {31'h0, mem_req}, 32'h1);
    chk("R8 busy", {31'h0, busy}, 32'h1);
    tick(); mem_busy = 1'b0; #1;
    chk("R8 req idle", {31'h0, mem_req}, 32'h0);
    chk("R8 busy low", {31'h0, busy}, 32'h0);

    // R9 status
    mload(1, 32'h0);
    chk("R9 zero set", {31'h0, zero}, 32'h1);
    mload(1, 32'h00000005);
    chk("R9 zero clear", {31'h0, zero}, 32'h0);
    mload(0, 32'hFC000000);
    chk("R9 opcode", {26'h0, opcode}, 32'h3F);

    // R10 reset clears again
    rst_n = 1'b0; #1;
    chk("R10 async ma clear", mem_addr, 32'h0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rpeek(3'd3, v); chk("R10 link cleared", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule